// File: doc/BRIEF.md
# PCM Time-Division Serial Port

This block moves one 16-bit mono playback stream and one 16-bit mono capture stream over a short-frame time-division serial link. A frame is a whole number of 8-bit-clock slots. The block places the transmit sample in one programmable window of bit clocks within that frame and reads the receive sample back from the same window. Data travels most significant bit first.

The bit clock comes from an enable input, `bclk_tick`. Each tick is one bit-clock edge, so the internal bit-clock level toggles on every tick. In master mode the block drives the bit clock and the frame sync out. In slave mode it holds its clock output low, leaves the frame-sync pin undriven, and aligns its frame position to an external sync. Four select bits choose which bit-clock edge drives data, captures data, drives sync and captures sync. A register stage or FIFO connects through a valid/ready handshake on the transmit side and a one-cycle valid pulse on the receive side.

Top module: `pcm_tdm_port`

## Requirements
- R1: In master mode, `cfg_slot_mode` values 0 to 5 give frames of 4, 8, 16, 32, 64 or 128 slots of 8 bit clocks each, which is 32 << code bit clocks. Codes 6 and 7 give 128 slots. The sync pulse repeats with that period.
- R2: Each `bclk_tick` toggles the bit clock, which starts low after reset. In master mode `bclk_out` follows it and `bclk_oe` is 1. In slave mode `bclk_out` stays 0 and `bclk_oe` is 0.
- R3: In master mode the sync is active for the first `cfg_sync_width` bit clocks of each frame, positions 0 onward. The active level equals `cfg_sync_pol` (1 = high active). The inactive level is its complement.
- R4: The transmit sample is sent MSB first on 16 consecutive bit clocks. It starts at frame position `cfg_slot_start`, and each bit is driven on the data drive edge.
- R5: At the slot start, if `tx_valid` is 1, the block takes `tx_data` and pulses `tx_ready` for one cycle, in the cycle the first bit appears on `sd_out`.
- R6: If `tx_valid` is 0 at the slot start, 16 zero bits are sent and `tx_underrun` pulses for one cycle. `tx_ready` stays 0.
- R7: When `cfg_tx_hiz` is 1, `sd_oe` is 0 outside the 16 slot bits. When it is 0, `sd_oe` is always 1 and `sd_out` is 0 outside the slot.
- R8: `sd_in` is captured MSB first on the data capture edge for the 16 slot positions. One cycle after the 16th capture, `rx_valid` pulses for one cycle with the sample on `rx_data`, which then holds.
- R9: In slave mode `fsync_oe` is 0. `fsync_in` is sampled on the sync capture edge. A change from inactive to active makes the next data drive edge frame position 0.
- R10: Edge selects (0 = rising, 1 = falling): `cfg_data_drv_fall` sets when `sd_out` changes, `cfg_data_cap_fall` sets when `sd_in` is sampled, `cfg_sync_drv_fall` sets when the sync changes and `cfg_sync_cap_fall` sets when `fsync_in` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_tick | input | 1 | One pulse per bit-clock edge |
| cfg_slot_mode | input | 3 | Slots-per-frame code |
| cfg_slot_start | input | 10 | Frame position of the first data bit |
| cfg_sync_width | input | 6 | Sync pulse width in bit clocks |
| cfg_sync_pol | input | 1 | Active sync level |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_tx_hiz | input | 1 | Float serial output outside the slot |
| cfg_data_drv_fall | input | 1 | Data driven on falling edge |
| cfg_data_cap_fall | input | 1 | Data captured on falling edge |
| cfg_sync_drv_fall | input | 1 | Sync driven on falling edge |
| cfg_sync_cap_fall | input | 1 | Sync captured on falling edge |
| bclk_out | output | 1 | Bit clock out (master) |
| bclk_oe | output | 1 | Bit clock output enable |
| fsync_out | output | 1 | Frame sync out |
| fsync_oe | output | 1 | Frame sync output enable |
| fsync_in | input | 1 | External frame sync (slave) |
| tx_data | input | 16 | Transmit sample |
| tx_valid | input | 1 | Transmit sample available |
| tx_ready | output | 1 | Transmit sample taken |
| tx_underrun | output | 1 | Slot started with no sample |
| sd_out | output | 1 | Serial data out |
| sd_oe | output | 1 | Serial data output enable |
| sd_in | input | 1 | Serial data in |
| rx_data | output | 16 | Received sample |
| rx_valid | output | 1 | Received sample strobe |

## Verification
The assertions assume that configuration inputs change only while reset is asserted. They also assume that the slot window `cfg_slot_start` + 16 fits inside the frame and that ticks are spaced so a capture edge never falls in two consecutive cycles. The bench changes the configuration only inside its reset task and sends one tick every other clock. It places every slot window well inside the selected frame. In slave mode it drives the external sync only after an observed rising edge, so the sync is stable at the capture edge that follows.

// File: rtl/pcm_tdm_pkg.sv
package pcm_tdm_pkg;
    localparam int unsigned SLOT_CODE_W   = 3;
    localparam int unsigned MAX_SLOT_CODE = 5;
    localparam int unsigned MIN_SLOTS     = 4;

    // Bit clocks per frame for a slot-mode code; codes above the limit clamp.
    function automatic int unsigned frame_bits(input logic [SLOT_CODE_W-1:0] code,
                                               input int unsigned slot_bits);
        int unsigned c;
        c = (32'(code) > MAX_SLOT_CODE) ? MAX_SLOT_CODE : 32'(code);
        return (slot_bits * MIN_SLOTS) << c;
    endfunction
endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
    import pcm_tdm_pkg::*;
#(
    parameter int unsigned SLOT_BITS = 8,
    parameter int unsigned SYNCW_W   = 6,
    parameter int unsigned POS_W     = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic [SLOT_CODE_W-1:0] slot_mode,
    input  logic [SYNCW_W-1:0]     sync_width,
    input  logic                   sync_pol,
    input  logic                   master,
    input  logic                   data_drv_fall,
    input  logic                   data_cap_fall,
    input  logic                   sync_drv_fall,
    input  logic                   sync_cap_fall,
    input  logic                   fsync_in,
    output logic                   bclk_lvl,
    output logic                   drv_edge,
    output logic                   cap_edge,
    output logic [POS_W-1:0]       pos_now,
    output logic [POS_W-1:0]       pos_nx,
    output logic                   fsync_line
);
    typedef struct packed {
        logic             bclk;
        logic [POS_W-1:0] pos;
        logic             fs_act;
        logic             fs_seen;
        logic             resync;
    } tmr_t;

    localparam tmr_t TMR_RST = '{bclk: 1'b0, pos: '1, fs_act: 1'b0,
                                 fs_seen: 1'b0, resync: 1'b0};

    tmr_t             tmr_q, tmr_d;
    logic             rise_c, fall_c, sdrv_c, scap_c, fs_in_act_c;
    logic [POS_W-1:0] last_c, pos_nx_c, sync_pos_c;

    always_comb begin
        tmr_d       = tmr_q;
        rise_c      = tick & ~tmr_q.bclk;
        fall_c      = tick & tmr_q.bclk;
        drv_edge    = data_drv_fall ? fall_c : rise_c;
        cap_edge    = data_cap_fall ? fall_c : rise_c;
        sdrv_c      = sync_drv_fall ? fall_c : rise_c;
        scap_c      = sync_cap_fall ? fall_c : rise_c;
        last_c      = POS_W'(frame_bits(slot_mode, SLOT_BITS) - 1);
        fs_in_act_c = (fsync_in == sync_pol);

        if (tick) begin
            tmr_d.bclk = ~tmr_q.bclk;
        end

        if (tmr_q.resync && !master) begin
            pos_nx_c = '0;
        end else if (tmr_q.pos >= last_c) begin
            pos_nx_c = '0;
        end else begin
            pos_nx_c = tmr_q.pos + 1'b1;
        end

        if (drv_edge) begin
            tmr_d.pos    = pos_nx_c;
            tmr_d.resync = 1'b0;
        end

        sync_pos_c = drv_edge ? pos_nx_c : tmr_q.pos;
        if (sdrv_c) begin
            tmr_d.fs_act = master && (32'(sync_pos_c) < 32'(sync_width));
        end

        if (scap_c) begin
            tmr_d.fs_seen = fs_in_act_c;
            if (fs_in_act_c && !tmr_q.fs_seen && !master) begin
                tmr_d.resync = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= TMR_RST;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign bclk_lvl   = tmr_q.bclk;
    assign pos_now    = tmr_q.pos;
    assign pos_nx     = pos_nx_c;
    assign fsync_line = tmr_q.fs_act ? sync_pol : ~sync_pol;

    // R2: the bit clock level moves only on a tick
    p_bclk_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(bclk_lvl));

    // R1: frame position advances only on the data drive edge
    p_pos_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_edge |=> $stable(pos_now));

    // R10: sync output changes only on the sync drive edge
    p_sync_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sdrv_c |=> $stable(tmr_q.fs_act));
endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot #(
    parameter int unsigned SAMPLE_W = 16,
    parameter int unsigned POS_W    = 10,
    parameter int unsigned START_W  = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                drv_edge,
    input  logic [POS_W-1:0]    pos_nx,
    input  logic [START_W-1:0]  slot_start,
    input  logic                tx_hiz,
    input  logic [SAMPLE_W-1:0] tx_data,
    input  logic                tx_valid,
    output logic                tx_ready,
    output logic                tx_underrun,
    output logic                sd_out,
    output logic                sd_oe
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] sh;
        logic                active;
        logic                ready;
        logic                under;
    } tx_t;

    tx_t         tx_q, tx_d;
    logic [31:0] p_c, s_c;

    always_comb begin
        tx_d       = tx_q;
        tx_d.ready = 1'b0;
        tx_d.under = 1'b0;
        p_c        = 32'(pos_nx);
        s_c        = 32'(slot_start);
        if (drv_edge) begin
            if (p_c == s_c) begin
                tx_d.active = 1'b1;
                if (tx_valid) begin
                    tx_d.sh    = tx_data;
                    tx_d.ready = 1'b1;
                end else begin
                    tx_d.sh    = '0;
                    tx_d.under = 1'b1;
                end
            end else if (p_c > s_c && p_c < s_c + SAMPLE_W) begin
                tx_d.sh     = {tx_q.sh[SAMPLE_W-2:0], 1'b0};
                tx_d.active = 1'b1;
            end else begin
                tx_d.sh     = '0;
                tx_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign sd_out      = tx_q.active & tx_q.sh[SAMPLE_W-1];
    assign sd_oe       = tx_q.active | ~tx_hiz;
    assign tx_ready    = tx_q.ready;
    assign tx_underrun = tx_q.under;

    // R5: the accepted sample's MSB is on the line in the ready cycle
    p_load_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (sd_oe && sd_out == $past(tx_data[SAMPLE_W-1])));

    // R6: an underrun slot starts by driving a zero
    p_under_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun |-> (sd_oe && !sd_out));

    // R4: the line moves only on a drive edge
    p_sd_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_edge |=> $stable(sd_out));
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot #(
    parameter int unsigned SAMPLE_W = 16,
    parameter int unsigned POS_W    = 10,
    parameter int unsigned START_W  = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_edge,
    input  logic [POS_W-1:0]    pos_now,
    input  logic [START_W-1:0]  slot_start,
    input  logic                sd_in,
    output logic [SAMPLE_W-1:0] rx_data,
    output logic                rx_valid
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] sh;
        logic [SAMPLE_W-1:0] data;
        logic                valid;
    } rx_t;

    rx_t                 rx_q, rx_d;
    logic [31:0]         p_c, s_c;
    logic [SAMPLE_W-1:0] nsh_c;

    always_comb begin
        rx_d       = rx_q;
        rx_d.valid = 1'b0;
        p_c        = 32'(pos_now);
        s_c        = 32'(slot_start);
        nsh_c      = {rx_q.sh[SAMPLE_W-2:0], sd_in};
        if (cap_edge && p_c >= s_c && p_c < s_c + SAMPLE_W) begin
            rx_d.sh = nsh_c;
            if (p_c == s_c + SAMPLE_W - 1) begin
                rx_d.data  = nsh_c;
                rx_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign rx_data  = rx_q.data;
    assign rx_valid = rx_q.valid;

    // R8: the receive strobe lasts one cycle
    p_rx_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R8: the received word holds after its strobe
    p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> $stable(rx_data));
endmodule

// File: rtl/pcm_tdm_port.sv
module pcm_tdm_port
    import pcm_tdm_pkg::*;
#(
    parameter int unsigned SAMPLE_W  = 16,
    parameter int unsigned SLOT_BITS = 8,
    parameter int unsigned START_W   = 10,
    parameter int unsigned SYNCW_W   = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bclk_tick,
    input  logic [SLOT_CODE_W-1:0] cfg_slot_mode,
    input  logic [START_W-1:0]     cfg_slot_start,
    input  logic [SYNCW_W-1:0]     cfg_sync_width,
    input  logic                   cfg_sync_pol,
    input  logic                   cfg_master,
    input  logic                   cfg_tx_hiz,
    input  logic                   cfg_data_drv_fall,
    input  logic                   cfg_data_cap_fall,
    input  logic                   cfg_sync_drv_fall,
    input  logic                   cfg_sync_cap_fall,
    output logic                   bclk_out,
    output logic                   bclk_oe,
    output logic                   fsync_out,
    output logic                   fsync_oe,
    input  logic                   fsync_in,
    input  logic [SAMPLE_W-1:0]    tx_data,
    input  logic                   tx_valid,
    output logic                   tx_ready,
    output logic                   tx_underrun,
    output logic                   sd_out,
    output logic                   sd_oe,
    input  logic                   sd_in,
    output logic [SAMPLE_W-1:0]    rx_data,
    output logic                   rx_valid
);
    localparam int unsigned MAX_FRAME = SLOT_BITS * MIN_SLOTS * (1 << MAX_SLOT_CODE);
    localparam int unsigned POS_W     = $clog2(MAX_FRAME);

    logic             bclk_lvl, drv_edge, cap_edge;
    logic [POS_W-1:0] pos_now, pos_nx;

    pcm_frame_timer #(
        .SLOT_BITS (SLOT_BITS),
        .SYNCW_W   (SYNCW_W),
        .POS_W     (POS_W)
    ) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (bclk_tick),
        .slot_mode     (cfg_slot_mode),
        .sync_width    (cfg_sync_width),
        .sync_pol      (cfg_sync_pol),
        .master        (cfg_master),
        .data_drv_fall (cfg_data_drv_fall),
        .data_cap_fall (cfg_data_cap_fall),
        .sync_drv_fall (cfg_sync_drv_fall),
        .sync_cap_fall (cfg_sync_cap_fall),
        .fsync_in      (fsync_in),
        .bclk_lvl      (bclk_lvl),
        .drv_edge      (drv_edge),
        .cap_edge      (cap_edge),
        .pos_now       (pos_now),
        .pos_nx        (pos_nx),
        .fsync_line    (fsync_out)
    );

    pcm_tx_slot #(
        .SAMPLE_W (SAMPLE_W),
        .POS_W    (POS_W),
        .START_W  (START_W)
    ) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .drv_edge    (drv_edge),
        .pos_nx      (pos_nx),
        .slot_start  (cfg_slot_start),
        .tx_hiz      (cfg_tx_hiz),
        .tx_data     (tx_data),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .tx_underrun (tx_underrun),
        .sd_out      (sd_out),
        .sd_oe       (sd_oe)
    );

    pcm_rx_slot #(
        .SAMPLE_W (SAMPLE_W),
        .POS_W    (POS_W),
        .START_W  (START_W)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_edge   (cap_edge),
        .pos_now    (pos_now),
        .slot_start (cfg_slot_start),
        .sd_in      (sd_in),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid)
    );

    assign bclk_out = cfg_master & bclk_lvl;
    assign bclk_oe  = cfg_master;
    assign fsync_oe = cfg_master;

    // R2: in slave mode the clock pin never goes high
    p_slave_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_master |-> !bclk_out);

    // R5: a sample is either taken or missing, never both
    p_ready_under_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_ready, tx_underrun}));
endmodule

// File: tb/pcm_tdm_port_test.sv
module pcm_tdm_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_tick = 1'b0;
    logic [2:0]  cfg_slot_mode;
    logic [9:0]  cfg_slot_start;
    logic [5:0]  cfg_sync_width;
    logic        cfg_sync_pol, cfg_master, cfg_tx_hiz;
    logic        cfg_data_drv_fall, cfg_data_cap_fall, cfg_sync_drv_fall, cfg_sync_cap_fall;
    logic        bclk_out, bclk_oe, fsync_out, fsync_oe, fsync_in;
    logic [15:0] tx_data;
    logic        tx_valid, tx_ready, tx_underrun, sd_out, sd_oe, sd_in;
    logic [15:0] rx_data;
    logic        rx_valid;

    always #5 clk = ~clk;

    pcm_tdm_port uut (
        .clk(clk), .rst_n(rst_n), .bclk_tick(bclk_tick),
        .cfg_slot_mode(cfg_slot_mode), .cfg_slot_start(cfg_slot_start),
        .cfg_sync_width(cfg_sync_width), .cfg_sync_pol(cfg_sync_pol),
        .cfg_master(cfg_master), .cfg_tx_hiz(cfg_tx_hiz),
        .cfg_data_drv_fall(cfg_data_drv_fall), .cfg_data_cap_fall(cfg_data_cap_fall),
        .cfg_sync_drv_fall(cfg_sync_drv_fall), .cfg_sync_cap_fall(cfg_sync_cap_fall),
        .bclk_out(bclk_out), .bclk_oe(bclk_oe), .fsync_out(fsync_out),
        .fsync_oe(fsync_oe), .fsync_in(fsync_in), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_underrun(tx_underrun),
        .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in), .rx_data(rx_data),
        .rx_valid(rx_valid)
    );

    // serial loopback
    assign sd_in = sd_oe ? sd_out : 1'b0;

    int   n_run = 0, n_fail = 0;
    bit   run = 1'b0;
    logic bmod = 1'b0;
    int   rise_cnt = 0, fall_cnt = 0;

    // bit-clock tick source and reference level model
    initial forever begin
        @(posedge clk);
        #1;
        if (bclk_tick) begin
            bmod = ~bmod;
            if (bmod) rise_cnt++;
            else      fall_cnt++;
        end
        @(negedge clk);
        bclk_tick = run && !bclk_tick;
    end

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic set_default();
        cfg_slot_mode = 3'd0;  cfg_slot_start = 10'd1; cfg_sync_width = 6'd1;
        cfg_sync_pol = 1'b1;   cfg_master = 1'b1;      cfg_tx_hiz = 1'b1;
        cfg_data_drv_fall = 1'b0; cfg_data_cap_fall = 1'b1;
        cfg_sync_drv_fall = 1'b0; cfg_sync_cap_fall = 1'b1;
        fsync_in = 1'b0; tx_valid = 1'b0; tx_data = '0;
    endtask

    task automatic apply_reset(bit start);
        run = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        bmod = 1'b0; rise_cnt = 0; fall_cnt = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        if (start) begin
            #2 run = 1'b1;
        end
    endtask

    // master-mode observation results
    int          e_fs, e_oe, e_sd, e_clk, n_ready, n_under, n_rxv, period;
    logic [15:0] last_rx;

    task automatic observe(int nrise, logic [15:0] smp, bit have_tx);
        int flen, seen, pos, last_act, off;
        bit act, inslot, prev_obs, obs, exp_bit;
        flen = 32 << ((cfg_slot_mode > 3'd5) ? 5 : int'(cfg_slot_mode));
        e_fs = 0; e_oe = 0; e_sd = 0; e_clk = 0; n_ready = 0; n_under = 0;
        n_rxv = 0; period = -1; last_rx = '0; last_act = -1; prev_obs = 1'b0;
        seen = rise_cnt;
        while (rise_cnt < nrise) begin
            @(negedge clk);
            if (bclk_out !== bmod) e_clk++;
            if (tx_ready) n_ready++;
            if (tx_underrun) n_under++;
            if (rx_valid) begin n_rxv++; last_rx = rx_data; end
            if (rise_cnt != seen) begin
                seen = rise_cnt;
                pos = (seen - 1) % flen;
                act = pos < int'(cfg_sync_width);
                if (fsync_out !== (act ? cfg_sync_pol : !cfg_sync_pol)) e_fs++;
                obs = (fsync_out === cfg_sync_pol);
                if (obs && !prev_obs) begin
                    if (last_act >= 0) period = seen - last_act;
                    last_act = seen;
                end
                prev_obs = obs;
                off = pos - int'(cfg_slot_start);
                inslot = off >= 0 && off < 16;
                exp_bit = inslot && have_tx ? smp[15 - off] : 1'b0;
                if (sd_oe !== (inslot || !cfg_tx_hiz)) e_oe++;
                if ((inslot || !cfg_tx_hiz) && sd_out !== exp_bit) e_sd++;
            end
        end
    endtask

    task automatic test_reset();
        set_default();
        apply_reset(1'b0);
        check(bclk_out == 1'b0, "R2", "bclk_out after reset", int'(bclk_out), 0);
        check(fsync_out == 1'b0, "R3", "fsync idle level after reset", int'(fsync_out), 0);
        check(sd_oe == 1'b0, "R7", "sd_oe after reset", int'(sd_oe), 0);
        check(!tx_ready && !tx_underrun && !rx_valid, "R8", "strobes after reset",
              int'({tx_ready, tx_underrun, rx_valid}), 0);
    endtask

    task automatic test_frame_len(logic [2:0] code);
        int flen;
        set_default();
        cfg_slot_mode = code;
        flen = 32 << ((code > 3'd5) ? 5 : int'(code));
        apply_reset(1'b1);
        observe(3 * flen + 2, 16'h0, 1'b0);
        check(period == flen, "R1", $sformatf("frame length code %0d", code), period, flen);
        check(e_clk == 0, "R2", "bclk_out follows bit clock", e_clk, 0);
        check(e_fs == 0, "R3", "sync pulse shape", e_fs, 0);
    endtask

    task automatic test_loopback(logic [15:0] smp);
        set_default();
        tx_valid = 1'b1; tx_data = smp;
        apply_reset(1'b1);
        observe(64, smp, 1'b1);
        check(e_sd == 0, "R4", $sformatf("serial bits of %h", smp), e_sd, 0);
        check(e_oe == 0, "R7", "sd_oe window with float", e_oe, 0);
        check(n_ready == 2 && n_under == 0, "R5", "tx_ready pulses", n_ready, 2);
        check(n_rxv == 2 && last_rx == smp, "R8", "loopback capture", int'(last_rx), int'(smp));
    endtask

    task automatic test_underrun();
        set_default();
        apply_reset(1'b1);
        observe(64, 16'h0, 1'b0);
        check(n_under == 2 && n_ready == 0, "R6", "underrun pulses", n_under, 2);
        check(e_sd == 0, "R6", "zeros sent on underrun", e_sd, 0);
        check(n_rxv == 2 && last_rx == 16'h0, "R8", "capture of zero slot", int'(last_rx), 0);
    endtask

    task automatic test_offset();
        set_default();
        cfg_slot_mode = 3'd1; cfg_slot_start = 10'd40;
        cfg_sync_width = 6'd4; cfg_sync_pol = 1'b0;
        tx_valid = 1'b1; tx_data = 16'h8001;
        apply_reset(1'b1);
        observe(128, 16'h8001, 1'b1);
        check(e_fs == 0, "R3", "width 4 low-active sync", e_fs, 0);
        check(e_sd == 0, "R4", "slot at offset 40", e_sd, 0);
        check(n_rxv == 2 && last_rx == 16'h8001, "R8", "capture at offset 40",
              int'(last_rx), 16'h8001);
    endtask

    task automatic test_no_hiz();
        set_default();
        cfg_tx_hiz = 1'b0;
        tx_valid = 1'b1; tx_data = 16'hFFFF;
        apply_reset(1'b1);
        observe(64, 16'hFFFF, 1'b1);
        check(e_oe == 0, "R7", "sd_oe held high", e_oe, 0);
        check(e_sd == 0, "R7", "sd_out low outside slot", e_sd, 0);
    endtask

    task automatic test_fall_drive();
        int bad_sd, bad_fs, changes, ready_on_rise, rxv, rs, fs;
        logic prev_sd, prev_fs;
        logic [15:0] got;
        set_default();
        cfg_data_drv_fall = 1'b1; cfg_data_cap_fall = 1'b0;
        cfg_sync_drv_fall = 1'b1;
        tx_valid = 1'b1; tx_data = 16'h6A59;
        apply_reset(1'b1);
        bad_sd = 0; bad_fs = 0; changes = 0; ready_on_rise = 0; rxv = 0; got = '0;
        prev_sd = sd_out; prev_fs = fsync_out; rs = rise_cnt; fs = fall_cnt;
        while (rise_cnt < 96) begin
            @(negedge clk);
            if (sd_out !== prev_sd) begin
                changes++;
                if (fall_cnt == fs) bad_sd++;
            end
            if (fsync_out !== prev_fs && fall_cnt == fs) bad_fs++;
            if (tx_ready && fall_cnt == fs) ready_on_rise++;
            if (rx_valid) begin rxv++; got = rx_data; end
            prev_sd = sd_out; prev_fs = fsync_out; rs = rise_cnt; fs = fall_cnt;
        end
        check(bad_sd == 0 && changes > 0, "R10", "data moves on falling edge", bad_sd, 0);
        check(bad_fs == 0, "R10", "sync moves on falling edge", bad_fs, 0);
        check(ready_on_rise == 0, "R5", "load on falling drive edge", ready_on_rise, 0);
        check(rxv >= 2 && got == 16'h6A59, "R10", "rising-edge capture", int'(got), 16'h6A59);
    endtask

    task automatic test_slave();
        int r0, r_ready, clk_hi, oe_bad;
        logic [15:0] got;
        set_default();
        cfg_master = 1'b0;
        tx_valid = 1'b1; tx_data = 16'hC3A5;
        apply_reset(1'b1);
        clk_hi = 0; oe_bad = 0; r_ready = -1; got = '0;
        while (rise_cnt < 10) begin
            @(negedge clk);
            if (bclk_out) clk_hi++;
            if (bclk_oe || fsync_oe) oe_bad++;
        end
        r0 = rise_cnt;
        fsync_in = 1'b1;
        while (rise_cnt < r0 + 40) begin
            @(negedge clk);
            if (rise_cnt == r0 + 1) fsync_in = 1'b0;
            if (bclk_out) clk_hi++;
            if (bclk_oe || fsync_oe) oe_bad++;
            if (tx_ready && r_ready < 0) r_ready = rise_cnt;
            if (rx_valid) got = rx_data;
        end
        check(clk_hi == 0 && oe_bad == 0, "R2", "slave outputs disabled", clk_hi + oe_bad, 0);
        check(r_ready == r0 + 2, "R9", "slot aligned to external sync", r_ready, r0 + 2);
        check(got == 16'hC3A5, "R9", "slave loopback", int'(got), 16'hC3A5);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #1_500_000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        test_reset();
        test_frame_len(3'd0);
        test_frame_len(3'd2);
        test_frame_len(3'd5);
        test_frame_len(3'd7);
        test_loopback(16'hA5C3);
        test_loopback(16'h0001);
        test_underrun();
        test_offset();
        test_no_hiz();
        test_fall_drive();
        test_slave();
        finish_run();
    end
endmodule